// File: doc/BRIEF.md
# Quadrant Memory Bank Controller

The controller sits between a processor's memory request port and the external memory devices on a 20-bit physical address space. The space is split into four quadrants by address bits 19:18. Each quadrant owns an 8-bit configuration register. Software writes these registers over a small internal I/O write port. A register fixes four things for its quadrant: how much each access is stretched, which upper address lines are flipped on the way out, whether write pulses are blocked, and which chip select and output-enable/write-enable pair carry the access.

A request is accepted while the block is idle. The block first latches the address, the direction and the configuration of the addressed quadrant. It then runs a fixed-length bus cycle and drives the active-low strobes from registered state. On the last clock of the cycle it raises a one-clock completion pulse. Requests that arrive during a cycle are ignored. The configuration registers have no read path.

Top module: `qbank_mem_ctrl`

## Requirements
- R1: A register write with address 0x14+q (q = 0..3) loads the configuration of quadrant q. A write to any other address changes no quadrant's behaviour. The quadrant of an access is given by request address bits 19:18.
- R2: After reset every configuration byte is 0x00. So every quadrant uses 4 added clocks, chip select 0, strobe pair 0, no inversion and no protection. While idle, all strobes are high and ready_o is high.
- R3: A read lasts 2+W clocks. W comes from config bits 7:6: 00→4, 01→2, 10→1, 11→0. The selected output enable is low on every clock of the read.
- R4: A write lasts 3+W clocks. The selected write enable is low from the second clock through the second-to-last clock, so it is low for W+1 clocks and never on the first or last clock.
- R5: Config bit 5 inverts outgoing address bit 19, and bit 4 inverts bit 18. The quadrant is chosen from the request address before inversion. The outgoing address holds steady for the whole cycle.
- R6: Config bit 3 blocks the write-enable pulse for writes into the quadrant. The cycle length is unchanged.
- R7: Config bit 2 selects the strobe pair: 0 drives oe_no[0]/we_no[0], and 1 drives oe_no[1]/we_no[1].
- R8: Config bits 1:0 select the chip select: 00→cs_no[0], 01→cs_no[1], 10 or 11→cs_no[2]. It is held low for the whole cycle.
- R9: During a cycle exactly one chip select is low and at most one OE or WE line is low. Every unselected strobe stays high.
- R10: done_o is high only on the final clock of a cycle. ready_o is low for the whole cycle. A request raised during a cycle is ignored, and the next request is accepted on the clock after done_o.
- R11: A configuration write made during a cycle does not alter that cycle. It applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Configuration register write strobe |
| reg_addr_i | input | 8 | Configuration register I/O address |
| reg_wdata_i | input | 8 | Configuration write data |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write access, 0 = read access |
| req_addr_i | input | 20 | Physical address of the access |
| ready_o | output | 1 | Idle; a request will be accepted |
| done_o | output | 1 | Final clock of the current cycle |
| mem_addr_o | output | 20 | Outgoing memory address after inversion |
| cs_no | output | 3 | Chip selects, active low |
| oe_no | output | 2 | Output enables, active low |
| we_no | output | 2 | Write enables, active low |

## Verification
The bench targets the four wait-state codes in both directions, including the zero-wait write. In that case a write pulse placed off by one clock would either vanish or run into the first or last clock. It sets up inversions whose outgoing address falls in another quadrant, so a design that selects the quadrant after inversion would raise the wrong chip select. It also sends a request into a busy cycle and rewrites a register in the middle of an access. A design that re-arbitrates mid-cycle or reads the configuration live would then show an extra completion or a changed strobe pattern. Writes to neighbouring I/O addresses catch loose address decoding.

// File: rtl/qbank_pkg.sv
package qbank_pkg;
  localparam int unsigned NUM_QUAD = 4;
  localparam int unsigned MAX_WAIT = 4;

  // field order is the register bit layout, msb first
  typedef struct packed {
    logic [1:0] wait_code;
    logic       inv_a19;
    logic       inv_a18;
    logic       wr_prot;
    logic       pair_sel;
    logic [1:0] cs_sel;
  } bank_cfg_t;

  function automatic logic [2:0] wait_clocks(logic [1:0] code);
    case (code)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      2'b10:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] cs_index(logic [1:0] sel);
    return sel[1] ? 2'd2 : {1'b0, sel[0]};
  endfunction
endpackage

// File: rtl/qbank_regfile.sv
module qbank_regfile
  import qbank_pkg::*;
#(
  parameter int unsigned IO_AW    = 8,
  parameter logic [7:0]  REG_BASE = 8'h14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [IO_AW-1:0]          addr_i,
  input  logic [7:0]                wdata_i,
  output bank_cfg_t [NUM_QUAD-1:0]  cfg_o
);
  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_reg
    localparam logic [IO_AW-1:0] MY_ADDR = IO_AW'(REG_BASE) + IO_AW'(q);
    bank_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cfg_q <= '0;
      else if (wr_i && addr_i == MY_ADDR) cfg_q <= bank_cfg_t'(wdata_i);
    end
    assign cfg_o[q] = cfg_q;
  end
endmodule

// File: rtl/qbank_cycle_ctrl.sv
module qbank_cycle_ctrl
  import qbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned READ_BASE  = 2,
  parameter int unsigned WRITE_BASE = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  bank_cfg_t [NUM_QUAD-1:0]  cfg_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      is_write_o,
  output logic                      we_window_o,
  output bank_cfg_t                 cur_cfg_o,
  output logic [ADDR_W-1:0]         cur_addr_o
);
  localparam int unsigned LEN_W = $clog2(WRITE_BASE + MAX_WAIT + 1);

  logic              busy_q, wr_q;
  logic [LEN_W-1:0]  idx_q, last_q, len_n;
  bank_cfg_t         cfg_q, sel_cfg;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign accept  = req_i && !busy_q;
  // quadrant chosen from the un-inverted request address
  assign sel_cfg = cfg_i[addr_i[ADDR_W-1 -: 2]];
  assign len_n   = (we_i ? LEN_W'(WRITE_BASE) : LEN_W'(READ_BASE))
                 + LEN_W'(wait_clocks(sel_cfg.wait_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      wr_q   <= we_i;
      idx_q  <= '0;
      last_q <= len_n - LEN_W'(1);
      cfg_q  <= sel_cfg;
      addr_q <= addr_i;
    end else if (busy_q) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + LEN_W'(1);
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = busy_q && (idx_q == last_q);
  assign is_write_o  = wr_q;
  assign we_window_o = busy_q && wr_q && (idx_q != '0) && (idx_q != last_q);
  assign cur_cfg_o   = cfg_q;
  assign cur_addr_o  = {addr_q[ADDR_W-1] ^ cfg_q.inv_a19,
                        addr_q[ADDR_W-2] ^ cfg_q.inv_a18,
                        addr_q[ADDR_W-3:0]};
endmodule

// File: rtl/qbank_strobe_route.sv
module qbank_strobe_route
  import qbank_pkg::*;
#(
  parameter int unsigned NUM_CS   = 3,
  parameter int unsigned NUM_PAIR = 2
) (
  input  logic                busy_i,
  input  logic                is_write_i,
  input  logic                we_window_i,
  input  bank_cfg_t           cfg_i,
  output logic [NUM_CS-1:0]   cs_no,
  output logic [NUM_PAIR-1:0] oe_no,
  output logic [NUM_PAIR-1:0] we_no
);
  logic [1:0] cs_idx;
  assign cs_idx = cs_index(cfg_i.cs_sel);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(busy_i && cs_idx == 2'(g));
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic hit;
    assign hit      = (cfg_i.pair_sel == 1'(p));
    assign oe_no[p] = !(busy_i && !is_write_i && hit);
    assign we_no[p] = !(we_window_i && !cfg_i.wr_prot && hit);
  end
endmodule

// File: rtl/qbank_mem_ctrl.sv
module qbank_mem_ctrl
  import qbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned IO_AW    = 8,
  parameter logic [7:0]  REG_BASE = 8'h14,
  parameter int unsigned NUM_CS   = 3,
  parameter int unsigned NUM_PAIR = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [IO_AW-1:0]    reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  input  logic                req_i,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  output logic                ready_o,
  output logic                done_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [NUM_CS-1:0]   cs_no,
  output logic [NUM_PAIR-1:0] oe_no,
  output logic [NUM_PAIR-1:0] we_no
);
  bank_cfg_t [NUM_QUAD-1:0] cfg;
  bank_cfg_t                cur_cfg;
  logic                     busy, is_write, we_window;

  qbank_regfile #(.IO_AW(IO_AW), .REG_BASE(REG_BASE)) i_regs (
    .clk_i, .rst_ni,
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .cfg_o  (cfg)
  );

  qbank_cycle_ctrl #(.ADDR_W(ADDR_W)) i_cycle (
    .clk_i, .rst_ni,
    .req_i,
    .we_i       (req_we_i),
    .addr_i     (req_addr_i),
    .cfg_i      (cfg),
    .busy_o     (busy),
    .done_o     (done_o),
    .is_write_o (is_write),
    .we_window_o(we_window),
    .cur_cfg_o  (cur_cfg),
    .cur_addr_o (mem_addr_o)
  );

  qbank_strobe_route #(.NUM_CS(NUM_CS), .NUM_PAIR(NUM_PAIR)) i_route (
    .busy_i     (busy),
    .is_write_i (is_write),
    .we_window_i(we_window),
    .cfg_i      (cur_cfg),
    .cs_no, .oe_no, .we_no
  );

  assign ready_o = !busy;
endmodule

// File: rtl/qbank_mem_ctrl_chk.sv
module qbank_mem_ctrl_chk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned NUM_CS   = 3,
  parameter int unsigned NUM_PAIR = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                ready_o,
  input logic                done_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [NUM_CS-1:0]   cs_no,
  input logic [NUM_PAIR-1:0] oe_no,
  input logic [NUM_PAIR-1:0] we_no
);
  AST_CS_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $countones(~cs_no) == 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (&cs_no && &oe_no && &we_no)); // R9
  AST_ONE_DATA_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~oe_no, ~we_no}) <= 1); // R9
  AST_WE_NOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(&cs_no) |-> &we_no); // R4
  AST_WE_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> &we_no); // R4
  AST_DONE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o); // R10
  AST_DONE_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o); // R10
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !$past(ready_o)) |-> $stable(mem_addr_o)); // R5
endmodule

bind qbank_mem_ctrl qbank_mem_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_PAIR(NUM_PAIR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
  .done_o(done_o), .mem_addr_o(mem_addr_o), .cs_no(cs_no),
  .oe_no(oe_no), .we_no(we_no)
);

// File: tb/test_qbank_mem_ctrl.sv
`timescale 1ns/1ps
module test_qbank_mem_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        req_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic        ready_o, done_o;
  logic [19:0] mem_addr_o;
  logic [2:0]  cs_no;
  logic [1:0]  oe_no, we_no;

  always #2.5 clk_i = ~clk_i;

  qbank_mem_ctrl i_qbank_mem_ctrl (.*);

  typedef struct {
    string tag;
    int    len, cs, pair, wr, prot;
    logic [19:0] addr;
  } item_t;

  item_t       sb_q[$];
  logic [7:0]  shadow [4];
  int total = 0, bad = 0, pushed = 0, done_cnt = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- driver ----------------
  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    if (a >= 8'h14 && a <= 8'h17) shadow[a - 8'h14] = d; // R1 decode
  endtask

  task automatic access_start(logic [19:0] a, bit wr, string tag);
    item_t it;
    logic [7:0] c;
    int w;
    c = shadow[a[19:18]];
    case (c[7:6]) 2'b00: w = 4; 2'b01: w = 2; 2'b10: w = 1; default: w = 0; endcase
    it.tag  = tag;
    it.len  = (wr ? 3 : 2) + w;
    it.cs   = c[1] ? 2 : int'(c[0]);
    it.pair = int'(c[2]);
    it.wr   = int'(wr);
    it.prot = int'(c[3]);
    it.addr = a ^ {c[5], c[4], 18'b0};
    sb_q.push_back(it);
    pushed++;
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = a; req_we_i = wr;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic access(logic [19:0] a, bit wr, string tag);
    access_start(a, wr, tag);
    wait_idle();
  endtask

  // ---------------- monitor ----------------
  int m_len, m_cs, m_oe0, m_oe1, m_we0, m_we1, m_wefirst, m_cs_move;
  logic [19:0] m_addr;

  always @(negedge clk_i) begin
    if (rst_ni && !ready_o) begin
      int ci;
      ci = -1;
      for (int g = 0; g < 3; g++) if (!cs_no[g]) ci = g;
      if (m_len == 0) begin
        m_cs = ci; m_addr = mem_addr_o; m_wefirst = int'(we_no != 2'b11);
        m_oe0 = 0; m_oe1 = 0; m_we0 = 0; m_we1 = 0; m_cs_move = 0;
      end else if (ci != m_cs) m_cs_move = 1;
      m_len++;
      m_oe0 += int'(!oe_no[0]); m_oe1 += int'(!oe_no[1]);
      m_we0 += int'(!we_no[0]); m_we1 += int'(!we_no[1]);
      if (done_o) begin
        item_t e;
        int ew;
        done_cnt++;
        if (sb_q.size() == 0) begin
          chk("R10", "unexpected completion", 1, 0);
        end else begin
          e  = sb_q.pop_front();
          ew = (e.wr != 0 && e.prot == 0) ? e.len - 2 : 0;
          chk(e.tag, e.wr != 0 ? "write length R4" : "read length R3", m_len, e.len);
          chk(e.tag, "chip select R8", m_cs, e.cs);
          chk(e.tag, "chip select held R8", m_cs_move, 0);
          chk(e.tag, "out address R5", int'(m_addr), int'(e.addr));
          chk(e.tag, "oe0 clocks R7", m_oe0, (e.wr == 0 && e.pair == 0) ? e.len : 0);
          chk(e.tag, "oe1 clocks R7", m_oe1, (e.wr == 0 && e.pair == 1) ? e.len : 0);
          chk(e.tag, "we0 clocks R6", m_we0, (e.pair == 0) ? ew : 0);
          chk(e.tag, "we1 clocks R6", m_we1, (e.pair == 1) ? ew : 0);
          chk(e.tag, "we on first clock R4", m_wefirst, 0);
          chk(e.tag, "we on last clock R4", int'(we_no != 2'b11), 0);
        end
        m_len = 0;
      end
    end else if (!rst_ni) m_len = 0;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int q = 0; q < 4; q++) shadow[q] = 8'h00;
    m_len = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2", "ready after reset", int'(ready_o), 1);
    chk("R2", "cs idle", int'(cs_no), 7);
    chk("R2", "oe idle", int'(oe_no), 3);
    chk("R2", "we idle", int'(we_no), 3);
    chk("R2", "done idle", int'(done_o), 0);

    access(20'h01234, 1'b0, "R2");          // 6-clock read, cs0, pair0
    access(20'h5ABCD, 1'b1, "R2");          // 7-clock write

    wr_reg(8'h13, 8'hFF);                   // R1: neighbours ignored
    wr_reg(8'h18, 8'hFF);
    access(20'h00010, 1'b1, "R1");

    wr_reg(8'h15, 8'hC5);                   // q1: 0 wait, pair1, cs1
    access(20'h40100, 1'b0, "R3");
    access(20'h40104, 1'b1, "R4");
    wr_reg(8'h16, 8'hB2);                   // q2: 1 wait, invert both, cs2
    access(20'h80040, 1'b0, "R5");
    wr_reg(8'h17, 8'h67);                   // q3: 2 wait, invert a19, pair1, cs 11
    access(20'hC1000, 1'b1, "R8");
    access(20'hC1004, 1'b0, "R7");

    wr_reg(8'h14, 8'hC8);                   // R6 protect, 0 wait
    access(20'h00020, 1'b1, "R6");
    wr_reg(8'h14, 8'h08);                   // R6 protect, 4 wait
    access(20'h00024, 1'b1, "R6");
    access(20'h00028, 1'b0, "R6");

    // R10: request during a busy cycle is ignored
    access_start(20'h00030, 1'b0, "R10");
    chk("R10", "ready low in cycle", int'(ready_o), 0);
    req_i = 1'b1; req_addr_i = 20'h40000; req_we_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    wait_idle();

    // R11: register rewrite in mid cycle does not touch current access
    wr_reg(8'h15, 8'h00);
    access_start(20'h40200, 1'b1, "R11");
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 8'h15; reg_wdata_i = 8'hCE;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    wait_idle();
    shadow[1] = 8'hCE;
    access(20'h40204, 1'b1, "R11");

    repeat (4) @(negedge clk_i);
    chk("R10", "completions", done_cnt, pushed);
    chk("R10", "scoreboard empty", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule